// File: doc/BRIEF.md
# Two-Read One-Write Register File with Hard-Wired Zero

This block holds a small set of general-purpose data registers for a simple datapath. Two read ports each take a register code and return the addressed value combinationally. One write port loads the register named by its code on a rising clock edge, but only when the write enable is high. Code zero names a constant-zero source. Codes above the populated range are empty. Both read as zero, and writes to them are dropped, so a datapath can throw a result away or use zero as an operand without extra muxing.

A synchronous active-low reset clears every stored register. A flat debug bus shows all stored registers at once, lowest-numbered register in the least significant slice. Data width, code width and register count are parameters. A parameter also selects between two read-port structures that behave the same.

Top module: `zreg_file`

## Requirements
- R1: While `rst_n` is low at a rising edge, every stored register is cleared at that edge, so `gpr_view` is all zero and every read returns zero afterwards.
- R2: When `wr_en` is high at a rising edge and `wr_sel` is a code from 1 to 4, the register with that number takes `wr_data` at that edge. No other register changes.
- R3: When `wr_en` is low at a rising edge, no register changes, whatever `wr_sel` and `wr_data` hold.
- R4: Code 0 always reads as zero on both ports. A write with `wr_sel` = 0 changes no register.
- R5: Codes 5, 6 and 7 read as zero on both ports. A write to any of them changes no register.
- R6: `rd_data_a` returns the register named by `rd_sel_a`, and `rd_data_b` returns the register named by `rd_sel_b`. Code k (1 to 4) names register k. Register k appears in `gpr_view[16*k-1 -: 16]`.
- R7: Reads are combinational. A register being written shows its old value on a read port up to the writing edge, and its new value straight after that edge. There is no bypass.
- R8: The two read ports work independently. Both may name the same register in the same cycle and get the same value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes and reset act on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the stored registers |
| rd_sel_a | input | 3 | Register code for read port A |
| rd_sel_b | input | 3 | Register code for read port B |
| wr_sel | input | 3 | Register code for the write port |
| wr_en | input | 1 | Write enable |
| wr_data | input | 16 | Value to store |
| rd_data_a | output | 16 | Value of the register named by `rd_sel_a` |
| rd_data_b | output | 16 | Value of the register named by `rd_sel_b` |
| gpr_view | output | 64 | All stored registers, register 1 in bits 15:0 |

## Verification
Each register is loaded with a distinct pattern and read back through both ports and the debug bus. A wrong code-to-register mapping or a write that lands on two registers therefore shows up as a mismatch. Writes are then sent with enable low, and to code 0 and codes 5 to 7, each carrying data that differs from every stored value. Any leak into storage changes a visible register. Read timing is probed either side of a writing edge to tell a combinational read without bypass from a registered or forwarded one. Both ports also read the same register in one cycle, and a second reset in mid-run confirms the clear.

// File: rtl/zreg_file_pkg.sv
package zreg_file_pkg;

   // Selects the structure of each read port.
   typedef enum logic [0:0] {
      RD_ANDOR = 1'b0,   // one-hot decode, AND-OR reduction
      RD_INDEX = 1'b1    // binary index into storage
   } rd_style_e;

   // True when a code names a populated register (1 .. num_gpr).
   function automatic logic code_is_gpr(input int unsigned code,
                                        input int unsigned num_gpr);
      return (code >= 1) && (code <= num_gpr);
   endfunction

endpackage

// File: rtl/zreg_code_decode.sv
module zreg_code_decode #(
   parameter int unsigned SEL_W   = 3,
   parameter int unsigned NUM_GPR = 4
) (
   input  logic [SEL_W-1:0]   code,
   output logic [NUM_GPR-1:0] hit
);
   // hit[k] selects stored register k+1; code 0 and unpopulated codes hit nothing.
   for (genvar k = 0; k < NUM_GPR; k++) begin : g_hit
      assign hit[k] = (code == SEL_W'(k + 1));
   end
endmodule

// File: rtl/zreg_storage.sv
module zreg_storage #(
   parameter int unsigned DATA_W  = 16,
   parameter int unsigned NUM_GPR = 4,
   localparam int unsigned FLAT_W = DATA_W * NUM_GPR
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [NUM_GPR-1:0] wr_hit,
   input  logic [DATA_W-1:0]  wr_data,
   output logic [FLAT_W-1:0]  regs_flat
);
   for (genvar k = 0; k < NUM_GPR; k++) begin : g_reg
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            q <= '0;
         end else if (wr_en && wr_hit[k]) begin
            q <= wr_data;
         end
      end
      assign regs_flat[k*DATA_W +: DATA_W] = q;
   end
endmodule

// File: rtl/zreg_read_port.sv
module zreg_read_port
   import zreg_file_pkg::*;
#(
   parameter int unsigned DATA_W   = 16,
   parameter int unsigned SEL_W    = 3,
   parameter int unsigned NUM_GPR  = 4,
   parameter rd_style_e   RD_STYLE = RD_ANDOR,
   localparam int unsigned FLAT_W  = DATA_W * NUM_GPR,
   localparam int unsigned IDX_W   = (NUM_GPR > 1) ? $clog2(NUM_GPR) : 1
) (
   input  logic [SEL_W-1:0]  sel,
   input  logic [FLAT_W-1:0] regs_flat,
   output logic [DATA_W-1:0] data
);
   if (RD_STYLE == RD_ANDOR) begin : g_andor
      logic [NUM_GPR-1:0] hit;

      zreg_code_decode #(
         .SEL_W   (SEL_W),
         .NUM_GPR (NUM_GPR)
      ) dec_i (
         .code (sel),
         .hit  (hit)
      );

      always_comb begin
         data = '0;
         for (int k = 0; k < NUM_GPR; k++) begin
            data = data | (regs_flat[k*DATA_W +: DATA_W] & {DATA_W{hit[k]}});
         end
      end
   end else begin : g_index
      logic             valid;
      logic [IDX_W-1:0] idx;

      always_comb begin
         valid = code_is_gpr(int'(sel), NUM_GPR);
         idx   = '0;
         if (valid) begin
            idx = IDX_W'(int'(sel) - 1);
         end
      end

      assign data = valid ? regs_flat[idx*DATA_W +: DATA_W] : '0;
   end
endmodule

// File: rtl/zreg_file.sv
module zreg_file
   import zreg_file_pkg::*;
#(
   parameter int unsigned DATA_W   = 16,
   parameter int unsigned SEL_W    = 3,
   parameter int unsigned NUM_GPR  = 4,
   parameter rd_style_e   RD_STYLE = RD_ANDOR,
   localparam int unsigned FLAT_W  = DATA_W * NUM_GPR
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SEL_W-1:0]  rd_sel_a,
   input  logic [SEL_W-1:0]  rd_sel_b,
   input  logic [SEL_W-1:0]  wr_sel,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data_a,
   output logic [DATA_W-1:0] rd_data_b,
   output logic [FLAT_W-1:0] gpr_view
);
   // Elaboration-time parameter checks.
   if (DATA_W < 1) begin : g_bad_width
      $error("zreg_file: DATA_W must be at least 1");
   end
   if (NUM_GPR < 1 || NUM_GPR > (2**SEL_W) - 1) begin : g_bad_count
      $error("zreg_file: NUM_GPR must lie in 1 .. 2**SEL_W-1 (code 0 is zero)");
   end

   logic [NUM_GPR-1:0] wr_hit;
   logic [FLAT_W-1:0]  regs_flat;

   zreg_code_decode #(
      .SEL_W   (SEL_W),
      .NUM_GPR (NUM_GPR)
   ) wr_dec_i (
      .code (wr_sel),
      .hit  (wr_hit)
   );

   zreg_storage #(
      .DATA_W  (DATA_W),
      .NUM_GPR (NUM_GPR)
   ) store_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_hit    (wr_hit),
      .wr_data   (wr_data),
      .regs_flat (regs_flat)
   );

   zreg_read_port #(
      .DATA_W   (DATA_W),
      .SEL_W    (SEL_W),
      .NUM_GPR  (NUM_GPR),
      .RD_STYLE (RD_STYLE)
   ) rd_a_i (
      .sel       (rd_sel_a),
      .regs_flat (regs_flat),
      .data      (rd_data_a)
   );

   zreg_read_port #(
      .DATA_W   (DATA_W),
      .SEL_W    (SEL_W),
      .NUM_GPR  (NUM_GPR),
      .RD_STYLE (RD_STYLE)
   ) rd_b_i (
      .sel       (rd_sel_b),
      .regs_flat (regs_flat),
      .data      (rd_data_b)
   );

   assign gpr_view = regs_flat;
endmodule

// File: rtl/zreg_file_chk.sv
module zreg_file_chk #(
   parameter int unsigned DATA_W  = 16,
   parameter int unsigned SEL_W   = 3,
   parameter int unsigned NUM_GPR = 4,
   localparam int unsigned FLAT_W = DATA_W * NUM_GPR
) (
   input logic              clk,
   input logic              rst_n,
   input logic [SEL_W-1:0]  rd_sel_a,
   input logic [SEL_W-1:0]  rd_sel_b,
   input logic [SEL_W-1:0]  wr_sel,
   input logic              wr_en,
   input logic [DATA_W-1:0] wr_data,
   input logic [DATA_W-1:0] rd_data_a,
   input logic [DATA_W-1:0] rd_data_b,
   input logic [FLAT_W-1:0] gpr_view
);
   // A reset edge leaves all storage cleared.
   assert_reset_clears_R1: assert property (@(posedge clk)
      !rst_n |=> (gpr_view == '0));

   // Code 0 reads zero on both ports.
   assert_zero_code_a_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_sel_a == '0) |-> (rd_data_a == '0));
   assert_zero_code_b_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_sel_b == '0) |-> (rd_data_b == '0));

   // Unpopulated codes read zero on both ports.
   assert_unpop_code_a_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(rd_sel_a) > NUM_GPR) |-> (rd_data_a == '0));
   assert_unpop_code_b_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(rd_sel_b) > NUM_GPR) |-> (rd_data_b == '0));

   for (genvar k = 0; k < NUM_GPR; k++) begin : g_reg
      // Enabled write to this code loads wr_data at the edge.
      assert_write_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && wr_sel == SEL_W'(k + 1))
         |=> (gpr_view[k*DATA_W +: DATA_W] == $past(wr_data)));

      // Without an enabled write to this code the register holds (R3, R4, R5).
      assert_hold_unless_named_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (!wr_en || wr_sel != SEL_W'(k + 1))
         |=> $stable(gpr_view[k*DATA_W +: DATA_W]));

      // Read ports return the named register (R6, R8).
      assert_port_a_maps_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_sel_a == SEL_W'(k + 1)) |-> (rd_data_a == gpr_view[k*DATA_W +: DATA_W]));
      assert_port_b_maps_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_sel_b == SEL_W'(k + 1)) |-> (rd_data_b == gpr_view[k*DATA_W +: DATA_W]));
   end
endmodule

bind zreg_file zreg_file_chk #(
   .DATA_W  (DATA_W),
   .SEL_W   (SEL_W),
   .NUM_GPR (NUM_GPR)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .rd_sel_a  (rd_sel_a),
   .rd_sel_b  (rd_sel_b),
   .wr_sel    (wr_sel),
   .wr_en     (wr_en),
   .wr_data   (wr_data),
   .rd_data_a (rd_data_a),
   .rd_data_b (rd_data_b),
   .gpr_view  (gpr_view)
);

// File: tb/zreg_file_tb_top.sv
`timescale 1ns/1ps
module zreg_file_tb_top;
   localparam int DW = 16;
   localparam int SW = 3;
   localparam int NG = 4;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [SW-1:0] rd_sel_a, rd_sel_b, wr_sel;
   logic          wr_en;
   logic [DW-1:0] wr_data;
   logic [DW-1:0] rd_data_a, rd_data_b;
   logic [DW*NG-1:0] gpr_view;

   int n_checks = 0;
   int n_fails  = 0;
   logic [DW-1:0] model [1:NG];

   always #2 clk = ~clk;   // 250 MHz

   zreg_file dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_sel_a  (rd_sel_a),
      .rd_sel_b  (rd_sel_b),
      .wr_sel    (wr_sel),
      .wr_en     (wr_en),
      .wr_data   (wr_data),
      .rd_data_a (rd_data_a),
      .rd_data_b (rd_data_b),
      .gpr_view  (gpr_view)
   );

   task automatic check(input string req, input string what,
                        input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s %s: actual 0x%04h expected 0x%04h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
   endtask

   // Drive a write at a falling edge, let the rising edge act, sample 1 ns after it.
   task automatic do_write(input logic [SW-1:0] sel, input logic [DW-1:0] d, input logic en);
      @(negedge clk);
      wr_sel = sel; wr_data = d; wr_en = en;
      @(posedge clk);
      #1;
      wr_en = 1'b0;
   endtask

   // Compare every stored register with the model, via the view and both ports.
   task automatic check_all(input string req);
      for (int k = 1; k <= NG; k++) begin
         check(req, $sformatf("view R%0d", k), gpr_view[k*DW-1 -: DW], model[k]);
      end
      for (int k = 1; k <= NG; k++) begin
         rd_sel_a = SW'(k); rd_sel_b = SW'(NG + 1 - k);
         #0.2;
         check(req, $sformatf("port A code %0d", k), rd_data_a, model[k]);
         check(req, $sformatf("port B code %0d", NG + 1 - k), rd_data_b, model[NG + 1 - k]);
      end
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (2) @(posedge clk);
      #1;
      for (int k = 1; k <= NG; k++) model[k] = '0;
      check_all("R1");
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic t_write_each();   // R2, R6
      logic [DW-1:0] pat [1:NG];
      pat[1] = 16'h1357; pat[2] = 16'h8001; pat[3] = 16'h00F0; pat[4] = 16'hFFFF;
      for (int k = 1; k <= NG; k++) begin
         do_write(SW'(k), pat[k], 1'b1);
         model[k] = pat[k];
         check_all("R2");
      end
      check_all("R6");
   endtask

   task automatic t_enable_low();   // R3
      for (int k = 1; k <= NG; k++) begin
         do_write(SW'(k), 16'hDEAD, 1'b0);
      end
      check_all("R3");
   endtask

   task automatic t_zero_code();    // R4
      do_write('0, 16'hBEEF, 1'b1);
      check_all("R4");
      rd_sel_a = '0; rd_sel_b = '0;
      #0.2;
      check("R4", "port A code 0", rd_data_a, '0);
      check("R4", "port B code 0", rd_data_b, '0);
   endtask

   task automatic t_unpopulated();  // R5
      for (int c = NG + 1; c < 2**SW; c++) begin
         do_write(SW'(c), 16'hA5A5 ^ DW'(c), 1'b1);
         rd_sel_a = SW'(c); rd_sel_b = SW'(c);
         #0.2;
         check("R5", $sformatf("port A code %0d", c), rd_data_a, '0);
         check("R5", $sformatf("port B code %0d", c), rd_data_b, '0);
      end
      check_all("R5");
   endtask

   task automatic t_read_timing();  // R7
      @(negedge clk);
      rd_sel_a = 3'd3; rd_sel_b = 3'd3;
      wr_sel = 3'd3; wr_data = 16'h4C4C; wr_en = 1'b1;
      #1;
      check("R7", "port A before edge", rd_data_a, model[3]);
      check("R7", "port B before edge", rd_data_b, model[3]);
      @(posedge clk);
      #0.5;
      wr_en = 1'b0;
      model[3] = 16'h4C4C;
      check("R7", "port A after edge", rd_data_a, model[3]);
      check("R7", "port B after edge", rd_data_b, model[3]);
   endtask

   task automatic t_same_register();  // R8
      for (int k = 1; k <= NG; k++) begin
         rd_sel_a = SW'(k); rd_sel_b = SW'(k);
         #0.2;
         check("R8", $sformatf("port A shared code %0d", k), rd_data_a, model[k]);
         check("R8", $sformatf("port B shared code %0d", k), rd_data_b, model[k]);
      end
   endtask

   initial begin
      rst_n = 1'b0; wr_en = 1'b0; wr_sel = '0; wr_data = '0;
      rd_sel_a = '0; rd_sel_b = '0;
      t_reset();
      t_write_each();
      t_enable_low();
      t_zero_code();
      t_unpopulated();
      t_read_timing();
      t_same_register();
      t_reset();          // R1 again after registers hold data
      summary();
      $finish;
   end

   initial begin
      #400000;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end
endmodule